// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller with Fast-Path Flags

This block gathers level-sensitive interrupt requests from three banks of sources and presents them to software through a small register window. The first bank holds eight local sources. The second and third banks hold thirty-two sources each. Each bank has a pending word that shows only its enabled, asserted sources. Each bank also has a pair of write strobes: one sets enable bits and one clears them.

The first bank's pending word is the top-level view a handler reads first. Above its own eight sources it carries one roll-up flag per wide bank. It also carries eleven fast-path flags, each a direct copy of one frequently used source in bank 1 or bank 2. That copy lets the handler identify those sources without a second read. When a fast-path source is pending, it does not raise its bank's roll-up flag. Neither the roll-up flags nor the fast-path flags can be masked from the first bank; a fast-path source is masked only through its own bank. A single registered request line goes to the processor.

Top module: `bank_irq_ctrl`

## Requirements
- R1: After reset every enable mask reads 0, the request output is low and every pending word reads 0, whatever the source inputs are.
- R2: Pending word 0 (offset 0x00) bits 7:0 equal the bank-0 source inputs ANDed with the bank-0 enable mask.
- R3: Pending words 1 and 2 (offsets 0x04 and 0x08) equal their bank's source inputs ANDed with that bank's enable mask.
- R4: Pending word 0 bit 8 is 1 exactly when an enabled bank-1 source without a fast-path flag is asserted; bit 9 is the same for bank 2.
- R5: Pending word 0 bits 10 to 14 copy the enabled bank-1 sources 7, 9, 10, 18 and 19, in that order from the low bit upward.
- R6: Pending word 0 bits 15 to 20 copy the enabled bank-2 sources 21, 22, 23, 24, 25 and 30, in that order from the low bit upward.
- R7: A pending fast-path source sets its flag in word 0 and its bit in its own bank word, but it never sets its bank's roll-up bit.
- R8: A write to an enable-set offset (0x18 bank 0, 0x10 bank 1, 0x14 bank 2) sets the mask bits written as 1 and leaves bits written as 0 unchanged. A read of either enable offset of a bank returns that bank's mask.
- R9: A write to an enable-clear offset (0x24 bank 0, 0x1c bank 1, 0x20 bank 2) clears the mask bits written as 1 and leaves the others unchanged.
- R10: Bank-0 enable writes affect only bits 7:0. Bits 8 to 31 of the bank-0 mask read 0, and the roll-up and fast-path flags are unaffected by any bank-0 enable write.
- R11: The request output is the OR of pending word 0 and changes one clock after that word changes.
- R12: Read data and its valid strobe appear one clock after the read request. Offsets outside the nine listed registers read 0, and bits 31:21 of pending word 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_b0 | input | 8 | Level requests of bank 0 |
| src_b1 | input | 32 | Level requests of bank 1 |
| src_b2 | input | 32 | Level requests of bank 2 |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one clock after a read |
| irq_out | output | 1 | Registered request to the processor |

## Verification
The hardest case to reach from the ports is a bank that has both a fast-path source and an ordinary source pending, with the fast-path source masked in its own bank while software tries to mask it from bank 0. The stimulus enables a wide bank fully and raises its fast-path sources one at a time, then all together, then together with an ordinary source, so that the roll-up bit stays low until the ordinary source arrives. It then writes ones over the upper bank-0 enable positions and confirms that the fast-path flags and the roll-up flag in word 0 read back unchanged. Finally it clears one fast-path source in its own bank and shows that both its flag and its bank bit disappear.

// File: rtl/bank_irq_pkg.sv
// Package: shared constants, register offsets and fast-path tables of the
// three-bank interrupt controller. Assumes byte offsets on 32-bit words.
package bank_irq_pkg;
    parameter int DATA_W  = 32;
    parameter int ADDR_W  = 6;
    parameter int NBANK   = 3;
    parameter int B0_SRC  = 8;
    parameter int WIDE_W  = 32;
    parameter int FP1_N   = 5;
    parameter int FP2_N   = 6;

    // Bit positions inside pending word 0 (software decodes these)
    localparam int ROLL1_BIT = B0_SRC;
    localparam int ROLL2_BIT = B0_SRC + 1;
    localparam int FP1_LSB   = B0_SRC + 2;
    localparam int FP2_LSB   = FP1_LSB + FP1_N;
    localparam int W0_USED   = FP2_LSB + FP2_N;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFF_PEND0 = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_PEND1 = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_PEND2 = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_SET1  = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_SET2  = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_SET0  = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_CLR1  = 6'h1c;
    localparam logic [ADDR_W-1:0] OFF_CLR2  = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_CLR0  = 6'h24;

    // Source index in a wide bank that feeds fast-path flag k
    function automatic int fp_src(input int bank, input int k);
        int r;
        r = 0;
        if (bank == 1) begin
            case (k)
                0: r = 7;   1: r = 9;   2: r = 10;
                3: r = 18;  default: r = 19;
            endcase
        end else begin
            case (k)
                0: r = 21;  1: r = 22;  2: r = 23;
                3: r = 24;  4: r = 25;  default: r = 30;
            endcase
        end
        return r;
    endfunction

    // Mask of the fast-path sources of one wide bank
    function automatic logic [WIDE_W-1:0] fp_mask(input int bank);
        logic [WIDE_W-1:0] m;
        int n;
        m = '0;
        n = (bank == 1) ? FP1_N : FP2_N;
        for (int k = 0; k < n; k++) m[fp_src(bank, k)] = 1'b1;
        return m;
    endfunction

    // Which mask bits of a bank software may write
    function automatic logic [DATA_W-1:0] writable(input int bank);
        logic [DATA_W-1:0] m;
        m = '0;
        if (bank == 0) m[B0_SRC-1:0] = '1;
        else           m[WIDE_W-1:0] = '1;
        return m;
    endfunction
endpackage

// File: rtl/bank_irq_enable.sv
// Module: one bank's enable mask with set-on-one and clear-on-one strobes.
// Assumes set and clear never arrive in the same cycle (distinct offsets).
module bank_irq_enable
    import bank_irq_pkg::*;
#(
    parameter logic [DATA_W-1:0] WR_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_stb,
    input  logic              clr_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en_q
);
    logic [DATA_W-1:0] bits_hit;

    // Restrict the write to the positions this bank owns
    always_comb bits_hit = wdata & WR_MASK;

    // Update the mask on a set or clear strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (set_stb) en_q <= en_q | bits_hit;
        else if (clr_stb) en_q <= en_q & ~bits_hit;
    end
endmodule

// File: rtl/bank_irq_status.sv
// Module: builds the three pending words. Word 0 carries the local sources,
// one roll-up flag per wide bank and the fast-path copies. Purely combinational.
module bank_irq_status
    import bank_irq_pkg::*;
(
    input  logic [B0_SRC-1:0]          src_b0,
    input  logic [WIDE_W-1:0]          src_b1,
    input  logic [WIDE_W-1:0]          src_b2,
    input  logic [NBANK-1:0][DATA_W-1:0] en_q,
    output logic [DATA_W-1:0]          pend0,
    output logic [DATA_W-1:0]          pend1,
    output logic [DATA_W-1:0]          pend2
);
    localparam logic [WIDE_W-1:0] FP1_MASK = fp_mask(1);
    localparam logic [WIDE_W-1:0] FP2_MASK = fp_mask(2);

    logic [B0_SRC-1:0] live0;
    logic [WIDE_W-1:0] live1, live2;
    logic [FP1_N-1:0]  fp1;
    logic [FP2_N-1:0]  fp2;
    logic              roll1, roll2;

    // Gate every source with its enable
    always_comb begin
        live0 = src_b0 & en_q[0][B0_SRC-1:0];
        live1 = src_b1 & en_q[1][WIDE_W-1:0];
        live2 = src_b2 & en_q[2][WIDE_W-1:0];
    end

    // Pick out the fast-path copies
    for (genvar k = 0; k < FP1_N; k++) begin : g_fp1
        assign fp1[k] = live1[fp_src(1, k)];
    end
    for (genvar k = 0; k < FP2_N; k++) begin : g_fp2
        assign fp2[k] = live2[fp_src(2, k)];
    end

    // Roll-up flags ignore the sources that have a fast path
    always_comb begin
        roll1 = |(live1 & ~FP1_MASK);
        roll2 = |(live2 & ~FP2_MASK);
    end

    // Assemble the pending words
    always_comb begin
        pend0 = '0;
        pend0[B0_SRC-1:0]            = live0;
        pend0[ROLL1_BIT]             = roll1;
        pend0[ROLL2_BIT]             = roll2;
        pend0[FP1_LSB +: FP1_N]      = fp1;
        pend0[FP2_LSB +: FP2_N]      = fp2;
        pend1 = '0;
        pend1[WIDE_W-1:0]            = live1;
        pend2 = '0;
        pend2[WIDE_W-1:0]            = live2;
    end
endmodule

// File: rtl/bank_irq_regif.sv
// Module: register window. Decodes writes into per-bank strobes and returns
// registered read data one clock after a read request.
module bank_irq_regif
    import bank_irq_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          pend0,
    input  logic [DATA_W-1:0]          pend1,
    input  logic [DATA_W-1:0]          pend2,
    input  logic [NBANK-1:0][DATA_W-1:0] en_q,
    output logic [NBANK-1:0]           set_stb,
    output logic [NBANK-1:0]           clr_stb,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       bus_rvalid
);
    typedef enum logic [2:0] {
        SEL_NONE, SEL_PEND0, SEL_PEND1, SEL_PEND2, SEL_EN0, SEL_EN1, SEL_EN2
    } reg_sel_t;

    reg_sel_t          which;
    logic [DATA_W-1:0] rd_mux;

    // Map the offset to a register
    always_comb begin
        case (bus_addr)
            OFF_PEND0:          which = SEL_PEND0;
            OFF_PEND1:          which = SEL_PEND1;
            OFF_PEND2:          which = SEL_PEND2;
            OFF_SET0, OFF_CLR0: which = SEL_EN0;
            OFF_SET1, OFF_CLR1: which = SEL_EN1;
            OFF_SET2, OFF_CLR2: which = SEL_EN2;
            default:            which = SEL_NONE;
        endcase
    end

    // Produce write strobes
    always_comb begin
        set_stb = '0;
        clr_stb = '0;
        if (bus_sel && bus_wr) begin
            case (bus_addr)
                OFF_SET0: set_stb[0] = 1'b1;
                OFF_SET1: set_stb[1] = 1'b1;
                OFF_SET2: set_stb[2] = 1'b1;
                OFF_CLR0: clr_stb[0] = 1'b1;
                OFF_CLR1: clr_stb[1] = 1'b1;
                OFF_CLR2: clr_stb[2] = 1'b1;
                default: ;
            endcase
        end
    end

    // Select the read value
    always_comb begin
        case (which)
            SEL_PEND0: rd_mux = pend0;
            SEL_PEND1: rd_mux = pend1;
            SEL_PEND2: rd_mux = pend2;
            SEL_EN0:   rd_mux = en_q[0];
            SEL_EN1:   rd_mux = en_q[1];
            SEL_EN2:   rd_mux = en_q[2];
            default:   rd_mux = '0;
        endcase
    end

    // Register read data and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_sel && !bus_wr;
            if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/bank_irq_ctrl.sv
// Module: top of the three-bank level interrupt controller. Holds the
// enable masks, builds pending words and registers the processor request.
// Assumes the sources are already synchronous to clk.
module bank_irq_ctrl
    import bank_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [B0_SRC-1:0]     src_b0,
    input  logic [WIDE_W-1:0]     src_b1,
    input  logic [WIDE_W-1:0]     src_b2,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_rvalid,
    output logic                  irq_out
);
    logic [NBANK-1:0][DATA_W-1:0] en_q;
    logic [NBANK-1:0]             set_stb, clr_stb;
    logic [DATA_W-1:0]            pend0, pend1, pend2;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_irq_enable #(.WR_MASK(writable(b))) u_en (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (set_stb[b]),
            .clr_stb (clr_stb[b]),
            .wdata   (bus_wdata),
            .en_q    (en_q[b])
        );
    end

    bank_irq_status u_status (
        .src_b0 (src_b0),
        .src_b1 (src_b1),
        .src_b2 (src_b2),
        .en_q   (en_q),
        .pend0  (pend0),
        .pend1  (pend1),
        .pend2  (pend2)
    );

    bank_irq_regif u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .pend0      (pend0),
        .pend1      (pend1),
        .pend2      (pend2),
        .en_q       (en_q),
        .set_stb    (set_stb),
        .clr_stb    (clr_stb),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    // Register the processor request from the top-level pending word
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |pend0;
    end
endmodule

// File: rtl/bank_irq_ctrl_chk.sv
// Checker: temporal properties of the controller, bound into the top.
module bank_irq_ctrl_chk
    import bank_irq_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic [WIDE_W-1:0]          src_b1,
    input logic [WIDE_W-1:0]          src_b2,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic                       bus_rvalid,
    input logic                       irq_out,
    input logic [NBANK-1:0][DATA_W-1:0] en_q,
    input logic [DATA_W-1:0]          pend0
);
    localparam logic [WIDE_W-1:0] M1 = fp_mask(1);
    localparam logic [WIDE_W-1:0] M2 = fp_mask(2);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && !irq_out && !bus_rvalid));

    assert_irq_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|pend0)));

    assert_fp_no_roll1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_b1 & en_q[1][WIDE_W-1:0] & ~M1) == '0) |-> !pend0[ROLL1_BIT]);

    assert_fp_no_roll2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_b2 & en_q[2][WIDE_W-1:0] & ~M2) == '0) |-> !pend0[ROLL2_BIT]);

    assert_set_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFF_SET1)
        |=> ((en_q[1] & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clear_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFF_CLR2)
        |=> ((en_q[2] & $past(bus_wdata)) == '0));

    assert_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    assert_no_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);
endmodule

bind bank_irq_ctrl bank_irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_b1     (src_b1),
    .src_b2     (src_b2),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .irq_out    (irq_out),
    .en_q       (en_q),
    .pend0      (pend0)
);

// File: tb/bank_irq_ctrl_bench.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module bank_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_b0 = '0;
    logic [31:0] src_b1 = '0, src_b2 = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, irq_out;

    typedef struct { logic [31:0] val; string tag; } exp_t;
    exp_t exp_q[$];
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    bank_irq_ctrl u_bank_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_b0(src_b0), .src_b1(src_b1),
        .src_b2(src_b2), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_out(irq_out)
    );

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        it.val = e; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        n_chk++;
        if (irq_out !== e) begin
            n_fail++;
            $display("FAIL %s irq_out actual=%b expected=%b", tag, irq_out, e);
        end
    endtask

    // Monitor: compare each returned read word with the queued expectation
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R12 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                if (bus_rdata !== it.val) begin
                    n_fail++;
                    $display("FAIL %s rdata actual=%h expected=%h", it.tag, bus_rdata, it.val);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        src_b0 = 8'hFF; src_b1 = '1; src_b2 = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(6'h18, 32'h0, "R1 en0");
        rd(6'h10, 32'h0, "R1 en1");
        rd(6'h14, 32'h0, "R1 en2");
        rd(6'h00, 32'h0, "R1 pend0");
        chk_irq(1'b0, "R1");
        src_b0 = '0; src_b1 = '0; src_b2 = '0;
        // R8/R10: bank-0 set keeps only bits 7:0
        wr(6'h18, 32'hFFFF_FF05);
        rd(6'h18, 32'h0000_0005, "R8 R10 en0 set");
        src_b0 = 8'h0F;
        rd(6'h00, 32'h0000_0005, "R2 pend0 low");
        chk_irq(1'b1, "R11 irq high");
        // R9: bank-0 clear
        wr(6'h24, 32'h0000_0004);
        rd(6'h24, 32'h0000_0001, "R9 en0 clear");
        rd(6'h00, 32'h0000_0001, "R2 pend0 after clear");
        wr(6'h24, 32'hFFFF_FF00);
        rd(6'h18, 32'h0000_0001, "R10 en0 upper clear ignored");
        wr(6'h18, 32'hFFFF_FF00);
        rd(6'h18, 32'h0000_0001, "R10 en0 upper set ignored");
        // Bank 1: roll-up and fast path
        src_b0 = '0;
        wr(6'h10, 32'hFFFF_FFFF);
        rd(6'h10, 32'hFFFF_FFFF, "R8 en1 set");
        src_b1 = 32'h0000_0008;
        rd(6'h04, 32'h0000_0008, "R3 pend1");
        rd(6'h00, 32'h0000_0100, "R4 roll1");
        src_b1 = 32'h0000_0080;
        rd(6'h00, 32'h0000_0400, "R5 R7 fp src7");
        rd(6'h04, 32'h0000_0080, "R3 R7 fp src7 in bank word");
        src_b1 = 32'h0000_0200;
        rd(6'h00, 32'h0000_0800, "R5 fp src9");
        src_b1 = 32'h0008_0000;
        rd(6'h00, 32'h0000_4000, "R5 fp src19");
        src_b1 = 32'h000C_0680;
        rd(6'h00, 32'h0000_7C00, "R5 R7 all fp1");
        src_b1 = 32'h000C_0688;
        rd(6'h00, 32'h0000_7D00, "R4 fp1 plus ordinary");
        // Bank 2
        src_b1 = '0;
        wr(6'h14, 32'hFFFF_FFFF);
        src_b2 = 32'h4000_0000;
        rd(6'h00, 32'h0010_0000, "R6 fp src30");
        src_b2 = 32'h0020_0000;
        rd(6'h00, 32'h0000_8000, "R6 fp src21");
        src_b2 = 32'h43E0_0000;
        rd(6'h00, 32'h001F_8000, "R6 R7 all fp2");
        src_b2 = 32'h0000_0001;
        rd(6'h00, 32'h0000_0200, "R4 roll2");
        src_b2 = 32'hC000_0000;
        rd(6'h00, 32'h0010_0200, "R4 R6 fp2 plus ordinary");
        rd(6'h08, 32'hC000_0000, "R3 pend2");
        // R10: bank-0 writes cannot mask fast-path or roll-up flags
        wr(6'h24, 32'h0010_0200);
        rd(6'h00, 32'h0010_0200, "R10 flags unmaskable");
        // R9: fast-path source masked in its own bank
        src_b2 = '0;
        wr(6'h1c, 32'h0000_0080);
        src_b1 = 32'h0000_0080;
        rd(6'h00, 32'h0000_0000, "R9 fp masked pend0");
        rd(6'h04, 32'h0000_0000, "R9 fp masked pend1");
        rd(6'h1c, 32'hFFFF_FF7F, "R9 en1 readback");
        wr(6'h20, 32'hFFFF_FFFF);
        rd(6'h14, 32'h0000_0000, "R9 en2 cleared");
        // R12: unmapped offsets
        rd(6'h0C, 32'h0, "R12 unmapped 0x0c");
        rd(6'h28, 32'h0, "R12 unmapped 0x28");
        // R11: one-clock lag of the request
        src_b1 = '0;
        @(negedge clk);
        @(negedge clk);
        chk_irq(1'b0, "R11 irq low");
        src_b1 = 32'h0000_0001;
        #1;
        chk_irq(1'b0, "R11 irq not yet");
        @(negedge clk);
        chk_irq(1'b1, "R11 irq after one clock");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R12 missing reads actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule